// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block gathers single-cycle event pulses from up to 22 device-side sources into a latched status vector and reports them to a host processor through a small synchronous register port. A per-source mask decides which latched events may drive the single host interrupt line. The line can be gated off and its active level chosen by configuration.

The host sees the same state through several windows. The mask can be written whole, or one bit at a time through a set alias and a clear alias, with no read-modify-write. Status can be read without disturbing it (peek) or read and wiped in one access (take). Individual status bits can be retired by writing ones to an acknowledge address. Only 14 of the 22 source positions are populated. The others are forced to zero everywhere.

Register map (3-bit address): 0 mask (read/write), 1 mask set (write), 2 mask clear (write), 3 status peek (read), 4 status take (read), 5 acknowledge (write), 6 line config (read/write; bit 0 enables the line, bit 1 set means active high). Reading a write-only address returns zero.

Top module: `hirq_ctrl`

## Requirements
- R1: A mask bit of 1 keeps that source's status bit from driving the host line. A mask bit of 0 lets it through. The line is active when the line is enabled and (status AND NOT mask) is nonzero.
- R2: After reset the mask reads 0x0001, status reads 0, the config reads 0 (line disabled, active low), and host_irq_o is 1.
- R3: A write to address 1 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to address 2 clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A read of address 3 returns the status vector and leaves it unchanged.
- R6: A read of address 4 returns the status vector and clears every status bit at the same edge.
- R7: A write to address 5 clears each status bit whose data bit is 1, and both read views show the change. Data bits of 0 have no effect.
- R8: Only source positions 0–10, 14, 16 and 17 exist (used mask 0x347FF). Pulses on other positions are ignored, and those bits read 0 in status and in the mask, even after writing all ones.
- R9: Config bit 1 selects the active level (1 means high, 0 means low). Config bit 0 enables the line. While the line is disabled it sits at its inactive level.
- R10: If a source pulse and a clear (acknowledge or take read) hit the same bit in the same cycle, the bit ends up set.
- R11: A source pulse sampled at edge E is visible to a read strobed at or after E+1. The host line reflects status and config with one register of delay. Read data appears on rdata_o the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 22 | Event pulses, one per source |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| host_irq_o | output | 1 | Host interrupt line, registered |

## Verification
A source pulse lands in status at the edge that samples it. A read strobed in that same cycle therefore returns the old value, and the next read returns the new one. Read data is due one edge after the strobe. The host line trails status and config by one more edge. The bench drives every input at the falling edge and advances its requirement model once per cycle, from the pre-edge state. Its monitor compares read data at the falling edge that follows the strobe, and the line at the falling edge after each operation. This lets the bench check both the settled value and the one-cycle lag.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  typedef enum logic [2:0] {
    A_MASK = 3'd0,
    A_MSET = 3'd1,
    A_MCLR = 3'd2,
    A_PEEK = 3'd3,
    A_TAKE = 3'd4,
    A_ACK  = 3'd5,
    A_CFG  = 3'd6
  } hirq_addr_e;

  localparam int CFG_EN_BIT = 0;
  localparam int CFG_AH_BIT = 1;
  localparam int CFG_W      = 2;
endpackage

// File: rtl/hirq_rst_sync.sv
module hirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/hirq_mask.sv
module hirq_mask #(
  parameter int              NSRC    = 22,
  parameter logic [NSRC-1:0] USED    = 22'h347FF,
  parameter logic [NSRC-1:0] RST_VAL = 22'h000001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_dir_i,
  input  logic            wr_set_i,
  input  logic            wr_clr_i,
  input  logic [NSRC-1:0] bits_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q, mask_d;
  logic            mask_en;

  always_comb begin
    mask_en = wr_dir_i | wr_set_i | wr_clr_i;
    mask_d  = mask_q;
    if (wr_dir_i)      mask_d = bits_i & USED;
    else if (wr_set_i) mask_d = (mask_q | bits_i) & USED;
    else if (wr_clr_i) mask_d = mask_q & ~bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= RST_VAL & USED;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_i |=> ((mask_q & ($past(bits_i) & USED)) == ($past(bits_i) & USED))
                 && ((mask_q & ~$past(bits_i)) == ($past(mask_q) & ~$past(bits_i))));
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i |=> ((mask_q & $past(bits_i)) == '0)
                 && ((mask_q & ~$past(bits_i)) == ($past(mask_q) & ~$past(bits_i))));
  // R8
  mask_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~USED) == '0);
endmodule

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int              NSRC = 22,
  parameter logic [NSRC-1:0] USED = 22'h347FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            ack_i,
  input  logic [NSRC-1:0] ack_bits_i,
  input  logic            take_i,
  output logic [NSRC-1:0] stat_o
);
  logic [NSRC-1:0] stat_q, stat_d, clr_vec, hit_vec;
  logic            stat_en;

  always_comb begin
    hit_vec = src_i & USED;
    clr_vec = '0;
    if (ack_i)  clr_vec = clr_vec | ack_bits_i;
    if (take_i) clr_vec = '1;
    stat_d  = (stat_q & ~clr_vec) | hit_vec;
    stat_en = ack_i | take_i | (|hit_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R10
  pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & USED)) |=> ((stat_q & $past(src_i & USED)) == $past(src_i & USED)));
  // R6
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ((src_i & USED) == '0)) |=> (stat_q == '0));
  // R7
  ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !take_i && ((src_i & USED) == '0))
      |=> ((stat_q & ~$past(ack_bits_i)) == ($past(stat_q) & ~$past(ack_bits_i))));
  // R8
  stat_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~USED) == '0);
endmodule

// File: rtl/hirq_line.sv
module hirq_line #(
  parameter int NSRC = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic            en_i,
  input  logic            ah_i,
  output logic            line_o
);
  logic line_q, line_d, active;

  always_comb begin
    active = en_i & (|pend_i);
    line_d = active ? ah_i : ~ah_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  assign line_o = line_q;

  // R9
  line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (line_o != $past(ah_i)));
  // R1
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> (line_o != $past(ah_i)));
  // R1
  line_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (pend_i != '0)) |=> (line_o == $past(ah_i)));
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
  import hirq_pkg::*;
#(
  parameter int              NSRC     = 22,
  parameter int              DW       = 32,
  parameter logic [NSRC-1:0] USED     = 22'h347FF,
  parameter logic [NSRC-1:0] MASK_RST = 22'h000001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [2:0]      addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            rd_en_i,
  output logic [DW-1:0]   rdata_o,
  output logic            host_irq_o
);
  localparam int PAD = DW - NSRC;

  logic            rst_sn;
  logic            wr_mask, wr_mset, wr_mclr, wr_ack, wr_cfg, rd_take;
  logic [NSRC-1:0] wbits, mask_v, stat_v, pend_v;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            unused_hi;

  hirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn)
  );

  always_comb begin
    wbits   = wdata_i[NSRC-1:0];
    wr_mask = wr_en_i && (addr_i == A_MASK);
    wr_mset = wr_en_i && (addr_i == A_MSET);
    wr_mclr = wr_en_i && (addr_i == A_MCLR);
    wr_ack  = wr_en_i && (addr_i == A_ACK);
    wr_cfg  = wr_en_i && (addr_i == A_CFG);
    rd_take = rd_en_i && (addr_i == A_TAKE);
  end

  assign unused_hi = ^wdata_i[DW-1:NSRC];

  hirq_mask #(.NSRC(NSRC), .USED(USED), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_sn),
    .wr_dir_i(wr_mask), .wr_set_i(wr_mset), .wr_clr_i(wr_mclr),
    .bits_i(wbits), .mask_o(mask_v)
  );

  hirq_status #(.NSRC(NSRC), .USED(USED)) u_stat (
    .clk(clk), .rst_n(rst_sn), .src_i(src_i),
    .ack_i(wr_ack), .ack_bits_i(wbits), .take_i(rd_take),
    .stat_o(stat_v)
  );

  assign pend_v = stat_v & ~mask_v;

  hirq_line #(.NSRC(NSRC)) u_line (
    .clk(clk), .rst_n(rst_sn), .pend_i(pend_v),
    .en_i(cfg_q[CFG_EN_BIT]), .ah_i(cfg_q[CFG_AH_BIT]),
    .line_o(host_irq_o)
  );

  always_comb cfg_d = wdata_i[CFG_W-1:0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cfg_q <= '0;
    else if (wr_cfg) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_d = '0;
    case (addr_i)
      A_MASK:          rdata_d = {{PAD{1'b0}}, mask_v};
      A_PEEK, A_TAKE:  rdata_d = {{PAD{1'b0}}, stat_v};
      A_CFG:           rdata_d = {{(DW-CFG_W){1'b0}}, cfg_q};
      default:         rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R5
  peek_view_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en_i && addr_i == A_PEEK) |=> (rdata_o[NSRC-1:0] == $past(stat_v)));
  // R5
  peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en_i && addr_i == A_PEEK && !wr_en_i && src_i == '0) |=> $stable(stat_v));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/test_hirq_ctrl.sv
module test_hirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] USED = 22'h347FF;
  localparam logic [2:0] A_MASK = 3'd0, A_MSET = 3'd1, A_MCLR = 3'd2,
                         A_PEEK = 3'd3, A_TAKE = 3'd4, A_ACK = 3'd5, A_CFG = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src_i = '0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        host_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [21:0] m_mask, m_stat;
  logic [1:0]  m_cfg;
  logic        m_line;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_v_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hirq_ctrl i_hirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .host_irq_o(host_irq_o)
  );

  always @(posedge clk) rd_v_q <= rd_en_i;

  // monitor: read data is due one edge after the strobe
  always @(negedge clk) begin
    if (rd_v_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", t, rdata_o, e);
      end
    end
  end

  // one cycle: drive at falling edge, model advances from the pre-edge state
  task automatic cyc(input logic [2:0] a, input logic w, input logic r,
                     input logic [31:0] d, input logic [21:0] s, input string tag);
    logic [21:0] clr;
    logic [31:0] rv;
    @(negedge clk);
    addr_i = a; wr_en_i = w; rd_en_i = r; wdata_i = d; src_i = s;
    rv = '0;
    case (a)
      A_MASK:         rv = {10'd0, m_mask};
      A_PEEK, A_TAKE: rv = {10'd0, m_stat};
      A_CFG:          rv = {30'd0, m_cfg};
      default:        rv = '0;
    endcase
    if (r) begin exp_q.push_back(rv); tag_q.push_back(tag); end
    m_line = (m_cfg[0] && ((m_stat & ~m_mask) != '0)) ? m_cfg[1] : ~m_cfg[1];
    clr = '0;
    if (w && a == A_ACK) clr = clr | d[21:0];
    if (r && a == A_TAKE) clr = '1;
    m_stat = (m_stat & ~clr) | (s & USED);
    if (w && a == A_MASK) m_mask = d[21:0] & USED;
    if (w && a == A_MSET) m_mask = (m_mask | d[21:0]) & USED;
    if (w && a == A_MCLR) m_mask = m_mask & ~d[21:0];
    if (w && a == A_CFG)  m_cfg = d[1:0];
  endtask

  task automatic idle();
    cyc(3'd7, 1'b0, 1'b0, '0, '0, "idle");
  endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(a, 1'b1, 1'b0, d, '0, "wr");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(a, 1'b0, 1'b1, '0, '0, tag);
  endtask
  task automatic pulse(input logic [21:0] s);
    cyc(3'd7, 1'b0, 1'b0, '0, s, "pulse");
  endtask

  // line check at the falling edge after the last operation
  task automatic chk_line(input string tag);
    @(negedge clk);
    checks++;
    if (host_irq_o !== m_line) begin
      errors++;
      $display("FAIL %s: host_irq_o actual %0b expected %0b", tag, host_irq_o, m_line);
    end
  endtask

  initial begin
    m_mask = 22'h1; m_stat = '0; m_cfg = '0; m_line = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    rd(A_MASK, "R2 mask reset");
    rd(A_PEEK, "R2 status reset");
    rd(A_CFG,  "R2 cfg reset");
    idle();
    checks++;
    if (host_irq_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 line reset: actual %0b expected 1", host_irq_o);
    end

    // R1 masked source does not reach the line
    pulse(22'h1);
    wr(A_CFG, 32'h1);
    idle(); chk_line("R1 masked source");
    wr(A_MCLR, 32'h1);
    idle(); chk_line("R1 unmasked source active low");
    rd(A_MASK, "R4 mask clear bit0");

    // R3 / R4 aliases
    wr(A_MSET, 32'h300); rd(A_MASK, "R3 mask set");
    wr(A_MSET, 32'h0);   rd(A_MASK, "R3 zero set no effect");
    wr(A_MCLR, 32'h100); rd(A_MASK, "R4 mask clear keeps others");

    // R5 peek
    pulse(22'h300);
    rd(A_PEEK, "R5 peek first");
    rd(A_PEEK, "R5 peek repeat");

    // R7 acknowledge
    wr(A_ACK, 32'h1); rd(A_PEEK, "R7 ack bit0");
    wr(A_ACK, 32'h0); rd(A_PEEK, "R7 ack zero no effect");
    idle(); chk_line("R1 bit8 unmasked pending");
    wr(A_MSET, 32'h100);
    idle(); chk_line("R1 all pending masked");

    // R9 polarity and enable
    wr(A_CFG, 32'h3);
    idle(); chk_line("R9 active high idle");
    wr(A_MASK, 32'h0);
    idle(); chk_line("R9 active high asserted");
    wr(A_CFG, 32'h2);
    idle(); chk_line("R9 disabled active high");
    rd(A_CFG, "R9 cfg readback");

    // R6 take
    rd(A_TAKE, "R6 take returns status");
    rd(A_PEEK, "R6 status cleared");

    // R8 unused positions
    pulse(22'h3FFFFF);
    rd(A_PEEK, "R8 unused status bits");
    wr(A_MASK, 32'hFFFFFFFF);
    rd(A_MASK, "R8 unused mask bits");
    rd(A_TAKE, "R6 take all");
    rd(A_MSET, "R8 write-only reads zero");

    // R10 pulse wins over clear
    cyc(A_TAKE, 1'b0, 1'b1, '0, 22'h10, "R10 take with pulse");
    rd(A_PEEK, "R10 pulse survives take");
    cyc(A_ACK, 1'b1, 1'b0, 32'h10, 22'h10, "R10 ack with pulse");
    rd(A_PEEK, "R10 pulse survives ack");
    wr(A_ACK, 32'h10);
    rd(A_PEEK, "R7 ack clears bit4");

    // R11 timing
    cyc(A_PEEK, 1'b0, 1'b1, '0, 22'h4, "R11 same-cycle read sees old");
    rd(A_PEEK, "R11 next read sees pulse");
    wr(A_CFG, 32'h1);
    wr(A_MASK, 32'h0);
    idle(); chk_line("R11 line asserted");
    wr(A_ACK, 32'h4);
    chk_line("R11 line lags ack by one cycle");
    idle(); chk_line("R11 line released");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule